// File: doc/BRIEF.md
# Raw NAND Strobe Timing Sequencer

This block turns byte-level requests from a register front end into correctly timed bus cycles on an 8-bit raw NAND device. Each request is a command byte, an address byte, a data byte to write or a data byte to read. For each one the block runs three phases in turn: setup, active strobe, then hold. It drives the latch-enable lines, the chip enable, the write and read strobes, and the output data bus.

All timing comes from one 32-bit word. The lower half holds the read-cycle counts and the upper half holds the write-cycle counts. After the strobe ends, the device ready/busy line is sampled after a programmable delay counted in pairs of clocks. The sampled level is kept as a status output. A busy flag tells the front end when the next request may be issued.

A control write can hold the chip enable low across a run of cycles, so that a multi-byte transaction stays selected. The same control write can also issue a soft reset. The soft reset aborts any cycle in progress and restores the timing word and the control settings to their defaults.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset, nand_ce_n, nand_we_n and nand_re_n are 1. nand_cle, nand_ale, nand_dq_oe, busy, rd_valid and dev_ready are 0. The timing word equals TIM_RESET (default 0).
- R2: On a write cycle (req_op 01 data, 10 command, 11 address), the setup field is timing bits 19:16, hold is bits 23:20 and width is bits 27:24. A field value v lasts v+1 clocks. nand_we_n falls after setup+1 busy clocks and stays low for width+1 clocks. Chip enable stays low for (setup+1)+(width+1)+(hold+1) clocks.
- R3: On a read cycle (req_op 00), the same rule applies to nand_re_n. Read setup is bits 3:0, read hold is bits 7:4 and read width is bits 11:8.
- R4: The ready-wait field (bits 15:12 for reads, bits 31:28 for writes) with value n delays the ready-line sample by 2*n clocks after the strobe ends. busy stays high until both the hold phase and this wait have finished.
- R5: nand_cle is high for the whole cycle only on command requests (req_op 10). nand_ale is high for the whole cycle only on address requests (req_op 11). Neither is high on data requests.
- R6: On write cycles, nand_dq_oe is high and nand_dq_out carries the request byte from the first setup clock to the last hold clock. On read cycles, nand_dq_oe stays low.
- R7: On a read cycle, nand_dq_in is captured on the rising edge of nand_re_n. The captured value appears on rd_byte with a one-clock rd_valid pulse.
- R8: While the force-CE setting (ctl_force_ce written with ctl_we) is 1, nand_ce_n stays low between and during cycles. While it is 0, nand_ce_n is high whenever no cycle is running.
- R9: dev_ready takes the level of nand_rb at the sample point of R4 and holds it until the next sample.
- R10: A request is accepted only when busy is low. A req_valid pulse while busy is ignored.
- R11: A control write with ctl_soft_rst set aborts any running cycle within one clock. It restores the timing word to TIM_RESET, clears force-CE and clears dev_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tim_we | input | 1 | Load the timing word |
| tim_wdata | input | 32 | New timing word |
| ctl_we | input | 1 | Control write strobe |
| ctl_force_ce | input | 1 | Force-CE setting written by ctl_we |
| ctl_soft_rst | input | 1 | Soft reset, acted on with ctl_we |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 00 data read, 01 data write, 10 command, 11 address |
| req_byte | input | 8 | Byte for write-type requests |
| busy | output | 1 | Cycle or ready wait in progress |
| rd_byte | output | 8 | Last byte read from the device |
| rd_valid | output | 1 | One-clock pulse when rd_byte is updated |
| dev_ready | output | 1 | Sampled device ready level |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data bus driven value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus sampled value |
| nand_rb | input | 1 | Device ready/busy line, 1 = ready |

## Verification
The hardest case to reach from the ports is the exact clock at which the ready line is sampled. That clock can fall inside the hold phase or after it, depending on how the hold count compares with twice the wait count. The stimulus flips nand_rb from 0 to 1 either on the last clock before the expected sample edge or on the clock just after it. It does this under random timing words, so that dev_ready must read 1 in the first case and 0 in the second. Requests injected while busy, a soft reset in the middle of a long cycle, and the all-zero and all-ones timing words cover the remaining boundaries.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam int TF_W   = 4;          // width of one timing field
  localparam int TWORD_W = 8 * TF_W;  // full timing word
  localparam int HALF_W  = TWORD_W / 2;
  localparam int WAIT_W  = TF_W + 1;  // holds 2*n

  typedef enum logic [1:0] {
    OP_RD  = 2'b00,
    OP_WR  = 2'b01,
    OP_CMD = 2'b10,
    OP_ADR = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  typedef struct packed {
    logic [TF_W-1:0] setup;
    logic [TF_W-1:0] hold;
    logic [TF_W-1:0] width;
    logic [TF_W-1:0] rwait;
  } dir_tim_t;

  // Select the half of the timing word for one direction and split it.
  function automatic dir_tim_t pick_dir(input logic [TWORD_W-1:0] word,
                                        input logic wr);
    logic [HALF_W-1:0] half;
    dir_tim_t f;
    half    = wr ? word[TWORD_W-1:HALF_W] : word[HALF_W-1:0];
    f.setup = half[TF_W-1:0];
    f.hold  = half[2*TF_W-1:TF_W];
    f.width = half[3*TF_W-1:2*TF_W];
    f.rwait = half[4*TF_W-1:3*TF_W];
    return f;
  endfunction

endpackage

// File: rtl/nand_tim_regs.sv
module nand_tim_regs
  import nand_seq_pkg::*;
#(
  parameter logic [TWORD_W-1:0] TIM_RESET = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tim_we,
  input  logic [TWORD_W-1:0] tim_wdata,
  input  logic               ctl_we,
  input  logic               ctl_force_ce,
  input  logic               ctl_soft_rst,
  output logic [TWORD_W-1:0] tim_q,
  output logic               force_ce_q,
  output logic               soft_clr
);

  logic [TWORD_W-1:0] tim_d;
  logic               force_d;

  assign soft_clr = ctl_we & ctl_soft_rst;

  always_comb begin
    tim_d   = tim_q;
    force_d = force_ce_q;
    if (soft_clr) begin
      tim_d   = TIM_RESET;
      force_d = 1'b0;
    end else begin
      if (tim_we) tim_d = tim_wdata;
      if (ctl_we) force_d = ctl_force_ce;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tim_q      <= TIM_RESET;
      force_ce_q <= 1'b0;
    end else begin
      tim_q      <= tim_d;
      force_ce_q <= force_d;
    end
  end

  // R11
  soft_clr_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (tim_q == TIM_RESET) && !force_ce_q);

endmodule

// File: rtl/nand_phase_fsm.sv
module nand_phase_fsm
  import nand_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               wait_busy,
  input  logic               req_valid,
  input  op_e                req_op,
  input  logic [DATA_W-1:0]  req_byte,
  input  logic [TWORD_W-1:0] tim_word,
  output phase_e             phase,
  output op_e                op_q,
  output logic [DATA_W-1:0]  byte_q,
  output logic               strobe_end,
  output logic [TF_W-1:0]    rwait
);

  phase_e          ph_q, ph_d;
  logic [TF_W-1:0] cnt_q, cnt_d;
  logic            accept;
  dir_tim_t        req_f, cur_f;

  assign accept = req_valid && (ph_q == PH_IDLE) && !wait_busy && !clr;
  assign req_f  = pick_dir(tim_word, req_op != OP_RD);
  assign cur_f  = pick_dir(tim_word, op_q != OP_RD);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (accept) begin
          ph_d  = PH_SETUP;
          cnt_d = req_f.setup;
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          ph_d  = PH_STROBE;
          cnt_d = cur_f.width;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_STROBE: begin
        if (cnt_q == '0) begin
          ph_d  = PH_HOLD;
          cnt_d = cur_f.hold;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_HOLD: begin
        if (cnt_q == '0) begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
    if (clr) begin
      ph_d  = PH_IDLE;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_RD;
      byte_q <= '0;
    end else if (accept) begin
      op_q   <= req_op;
      byte_q <= req_byte;
    end
  end

  assign phase      = ph_q;
  assign strobe_end = (ph_q == PH_STROBE) && (cnt_q == '0) && !clr;
  assign rwait      = cur_f.rwait;

  // R2
  setup_to_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SETUP) |=> (ph_q == PH_SETUP || ph_q == PH_STROBE || ph_q == PH_IDLE));

  // R3
  hold_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_HOLD) |=> (ph_q == PH_HOLD || ph_q == PH_IDLE));

  // R10
  req_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE) |=> ($stable(op_q) && $stable(byte_q)));

endmodule

// File: rtl/nand_rdy_sampler.sv
module nand_rdy_sampler
  import nand_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            start,
  input  logic [TF_W-1:0] rwait,
  input  logic            rb,
  output logic            pend,
  output logic            ready_q
);

  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              pend_d, ready_d;

  always_comb begin
    cnt_d   = cnt_q;
    pend_d  = pend;
    ready_d = ready_q;
    if (clr) begin
      cnt_d   = '0;
      pend_d  = 1'b0;
      ready_d = 1'b0;
    end else if (start) begin
      if (rwait == '0) begin
        ready_d = rb;
      end else begin
        cnt_d  = {rwait, 1'b0};
        pend_d = 1'b1;
      end
    end else if (pend) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == WAIT_W'(1)) begin
        ready_d = rb;
        pend_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pend    <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pend    <= pend_d;
      ready_q <= ready_d;
    end
  end

  // R4
  pend_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (cnt_q != '0));

  // R9
  ready_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ready_q) |-> ($past(clr) || $past(start) || $past(pend)));

endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nand_seq_pkg::*;
#(
  parameter int                 DATA_W    = 8,
  parameter logic [TWORD_W-1:0] TIM_RESET = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tim_we,
  input  logic [TWORD_W-1:0] tim_wdata,
  input  logic               ctl_we,
  input  logic               ctl_force_ce,
  input  logic               ctl_soft_rst,
  input  logic               req_valid,
  input  logic [1:0]         req_op,
  input  logic [DATA_W-1:0]  req_byte,
  output logic               busy,
  output logic [DATA_W-1:0]  rd_byte,
  output logic               rd_valid,
  output logic               dev_ready,
  output logic               nand_ce_n,
  output logic               nand_cle,
  output logic               nand_ale,
  output logic               nand_we_n,
  output logic               nand_re_n,
  output logic [DATA_W-1:0]  nand_dq_out,
  output logic               nand_dq_oe,
  input  logic [DATA_W-1:0]  nand_dq_in,
  input  logic               nand_rb
);

  logic [TWORD_W-1:0] tim_q;
  logic               force_ce_q;
  logic               soft_clr;
  phase_e             phase;
  op_e                op_q;
  logic [DATA_W-1:0]  byte_q;
  logic               strobe_end;
  logic [TF_W-1:0]    rwait;
  logic               pend;
  logic               active, is_wr, strobe_on;
  logic               rd_cap;
  logic               rd_valid_d;
  logic [DATA_W-1:0]  rd_byte_d;

  nand_tim_regs #(.TIM_RESET(TIM_RESET)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .tim_we       (tim_we),
    .tim_wdata    (tim_wdata),
    .ctl_we       (ctl_we),
    .ctl_force_ce (ctl_force_ce),
    .ctl_soft_rst (ctl_soft_rst),
    .tim_q        (tim_q),
    .force_ce_q   (force_ce_q),
    .soft_clr     (soft_clr)
  );

  nand_phase_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (soft_clr),
    .wait_busy  (pend),
    .req_valid  (req_valid),
    .req_op     (op_e'(req_op)),
    .req_byte   (req_byte),
    .tim_word   (tim_q),
    .phase      (phase),
    .op_q       (op_q),
    .byte_q     (byte_q),
    .strobe_end (strobe_end),
    .rwait      (rwait)
  );

  nand_rdy_sampler u_rdy (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (soft_clr),
    .start   (strobe_end),
    .rwait   (rwait),
    .rb      (nand_rb),
    .pend    (pend),
    .ready_q (dev_ready)
  );

  assign active    = (phase != PH_IDLE);
  assign is_wr     = (op_q != OP_RD);
  assign strobe_on = (phase == PH_STROBE);

  assign busy        = active | pend;
  assign nand_ce_n   = !(active || force_ce_q);
  assign nand_cle    = active && (op_q == OP_CMD);
  assign nand_ale    = active && (op_q == OP_ADR);
  assign nand_we_n   = !(strobe_on && is_wr);
  assign nand_re_n   = !(strobe_on && !is_wr);
  assign nand_dq_oe  = active && is_wr;
  assign nand_dq_out = nand_dq_oe ? byte_q : '0;

  // Read capture on the edge where the read strobe returns high.
  assign rd_cap = strobe_end && !is_wr;

  always_comb begin
    rd_valid_d = rd_cap;
    rd_byte_d  = rd_cap ? nand_dq_in : rd_byte;
    if (soft_clr) rd_valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_byte  <= '0;
    end else begin
      rd_valid <= rd_valid_d;
      rd_byte  <= rd_byte_d;
    end
  end

  // R5
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  // R6
  wr_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> (nand_dq_oe && !nand_ce_n));

  // R7
  rd_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $rose(nand_re_n));

  // R4
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (nand_we_n && nand_re_n && !nand_dq_oe));

endmodule

// File: tb/nand_cycle_seq_bench.sv
module nand_cycle_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tim_we, ctl_we, ctl_force_ce, ctl_soft_rst, req_valid;
  logic [31:0] tim_wdata;
  logic [1:0]  req_op;
  logic [7:0]  req_byte, nand_dq_in;
  logic        nand_rb;
  logic        busy, rd_valid, dev_ready, nand_ce_n, nand_cle, nand_ale;
  logic        nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  rd_byte, nand_dq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  nand_cycle_seq u_nand_cycle_seq (
    .clk(clk), .rst_n(rst_n), .tim_we(tim_we), .tim_wdata(tim_wdata),
    .ctl_we(ctl_we), .ctl_force_ce(ctl_force_ce), .ctl_soft_rst(ctl_soft_rst),
    .req_valid(req_valid), .req_op(req_op), .req_byte(req_byte),
    .busy(busy), .rd_byte(rd_byte), .rd_valid(rd_valid), .dev_ready(dev_ready),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic int busy_len(input int s, input int w, input int h, input int n);
    int a, b;
    a = s + w + h + 3;
    b = s + w + 2 + 2 * n;
    return (a > b) ? a : b;
  endfunction

  task automatic set_tim(input logic [31:0] wd);
    @(negedge clk);
    tim_we = 1'b1; tim_wdata = wd;
    @(negedge clk);
    tim_we = 1'b0;
  endtask

  task automatic set_ctl(input bit frc, input bit srst);
    @(negedge clk);
    ctl_we = 1'b1; ctl_force_ce = frc; ctl_soft_rst = srst;
    @(negedge clk);
    ctl_we = 1'b0; ctl_force_ce = 1'b0; ctl_soft_rst = 1'b0;
  endtask

  // One full request; wd is the timing word the design is expected to use.
  task automatic run_cycle(input logic [1:0] op, input logic [7:0] b,
                           input logic [31:0] wd, input bit force_on,
                           input int flip, input bit inj);
    bit wr, rbc, rexp, stb, oth;
    logic [15:0] half;
    logic [7:0] din, rdb;
    int s, w, h, n, tot, k, flipk;
    int st_first, st_cnt, wrong_st, ce_cnt, cle_cnt, ale_cnt, oe_cnt, dq_bad, rdk;
    string dtag;
    wr   = (op != 2'b00);
    dtag = wr ? "R2" : "R3";
    half = wr ? wd[31:16] : wd[15:0];
    s = int'(half[3:0]); h = int'(half[7:4]); w = int'(half[11:8]); n = int'(half[15:12]);
    tot   = s + w + h + 3;
    flipk = (flip >= 0) ? (s + w + 2 + 2 * n + flip) : -1;
    st_first = 0; st_cnt = 0; wrong_st = 0; ce_cnt = 0; cle_cnt = 0;
    ale_cnt = 0; oe_cnt = 0; dq_bad = 0; rdk = 0; rdb = '0;
    @(negedge clk);
    din = 8'($urandom);
    rbc = 1'($urandom);
    nand_dq_in = din;
    nand_rb    = (flip >= 0) ? 1'b0 : rbc;
    rexp       = (flip == 0) ? 1'b1 : ((flip == 1) ? 1'b0 : rbc);
    req_valid = 1'b1; req_op = op; req_byte = b;
    @(negedge clk);
    req_valid = 1'b0;
    k = 1;
    while (busy && k < 500) begin
      stb = wr ? !nand_we_n : !nand_re_n;
      oth = wr ? !nand_re_n : !nand_we_n;
      if (stb) begin
        if (st_first == 0) st_first = k;
        st_cnt++;
      end
      if (oth) wrong_st++;
      if (!nand_ce_n) ce_cnt++;
      if (nand_cle) cle_cnt++;
      if (nand_ale) ale_cnt++;
      if (nand_dq_oe) begin
        oe_cnt++;
        if (nand_dq_out != b) dq_bad++;
      end
      if (rd_valid) begin rdk = k; rdb = rd_byte; end
      if (k == flipk) nand_rb = 1'b1;
      if (inj && k == 2) begin req_valid = 1'b1; req_op = ~op; req_byte = ~b; end
      if (inj && k == 3) req_valid = 1'b0;
      @(negedge clk);
      k++;
    end
    chk({dtag, " setup length (clocks before strobe)"}, st_first, s + 2);
    chk({dtag, " strobe width"}, st_cnt, w + 1);
    chk({dtag, " opposite strobe stays high"}, wrong_st, 0);
    if (force_on) begin
      chk("R8 ce low during forced cycle", ce_cnt, k - 1);
      chk("R8 ce low after forced cycle", int'(nand_ce_n), 0);
    end else begin
      chk({dtag, " setup+width+hold span on ce"}, ce_cnt, tot);
      chk("R8 ce high after cycle", int'(nand_ce_n), 1);
    end
    chk("R4 busy length", k - 1, busy_len(s, w, h, n));
    chk("R5 cle clocks", cle_cnt, (op == 2'b10) ? tot : 0);
    chk("R5 ale clocks", ale_cnt, (op == 2'b11) ? tot : 0);
    chk("R6 bus drive clocks", oe_cnt, wr ? tot : 0);
    chk("R6 bus value", dq_bad, 0);
    if (!wr) begin
      chk("R7 capture clock", rdk, s + w + 3);
      chk("R7 captured byte", int'(rdb), int'(din));
    end else begin
      chk("R7 no read pulse on write", rdk, 0);
    end
    chk("R9 sampled ready", int'(dev_ready), int'(rexp));
    if (inj) begin
      repeat (2) @(negedge clk);
      chk("R10 request during busy ignored", int'(busy), 0);
      chk("R10 no strobe after ignored request", int'(nand_we_n & nand_re_n), 1);
    end
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd2024);
    rst_n = 1'b0;
    tim_we = 1'b0; tim_wdata = '0; ctl_we = 1'b0; ctl_force_ce = 1'b0;
    ctl_soft_rst = 1'b0; req_valid = 1'b0; req_op = '0; req_byte = '0;
    nand_dq_in = '0; nand_rb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 idle state
    chk("R1 ce_n", int'(nand_ce_n), 1);
    chk("R1 strobes", int'(nand_we_n & nand_re_n), 1);
    chk("R1 latches/oe", int'(nand_cle | nand_ale | nand_dq_oe), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 rd_valid/dev_ready", int'(rd_valid | dev_ready), 0);
    // R1 default timing word is zero
    run_cycle(2'b01, 8'hA5, 32'h0, 1'b0, -1, 1'b0);

    // Directed extremes
    set_tim(32'hFFFF_FFFF);
    run_cycle(2'b00, 8'h00, 32'hFFFF_FFFF, 1'b0, 0, 1'b0);
    run_cycle(2'b10, 8'h70, 32'hFFFF_FFFF, 1'b0, 1, 1'b1);
    set_tim(32'h0F01_F120);
    run_cycle(2'b11, 8'h3C, 32'h0F01_F120, 1'b0, 0, 1'b0);
    run_cycle(2'b00, 8'h00, 32'h0F01_F120, 1'b0, 1, 1'b1);

    // R8 forced chip enable
    set_ctl(1'b1, 1'b0);
    chk("R8 ce forced low while idle", int'(nand_ce_n), 0);
    run_cycle(2'b01, 8'h5A, 32'h0F01_F120, 1'b1, -1, 1'b0);
    run_cycle(2'b00, 8'h00, 32'h0F01_F120, 1'b1, 0, 1'b0);
    set_ctl(1'b0, 1'b0);
    chk("R8 ce released", int'(nand_ce_n), 1);

    // Random mix
    for (int i = 0; i < 60; i++) begin
      logic [31:0] wd;
      wd = $urandom;
      set_tim(wd);
      run_cycle(2'($urandom), 8'($urandom), wd, 1'b0,
                int'($urandom % 3) - 1, ($urandom % 4) == 0);
    end

    // R11 soft reset in the middle of a long cycle
    set_tim(32'hFFFF_FFFF);
    set_ctl(1'b1, 1'b0);
    nand_rb = 1'b1;
    run_cycle(2'b00, 8'h00, 32'hFFFF_FFFF, 1'b1, -1, 1'b0);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'b01; req_byte = 8'hC3;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 busy before soft reset", int'(busy), 1);
    set_ctl(1'b0, 1'b1);
    chk("R11 busy cleared", int'(busy), 0);
    chk("R11 ce released (force cleared)", int'(nand_ce_n), 1);
    chk("R11 bus released", int'(nand_dq_oe), 0);
    chk("R11 ready cleared", int'(dev_ready), 0);
    run_cycle(2'b01, 8'h96, 32'h0, 1'b0, -1, 1'b0);

    finish_run();
  end

endmodule